// File: doc/BRIEF.md
# I2C Bus Clear Recovery Engine

This block frees an I2C bus whose data line is held low by a slave that lost track of a transfer. When software enables it, the engine takes the bus and drives clock pulses on SCL through an open-drain output. It samples SDA in the high phase of every pulse and stops clocking as soon as the slave lets SDA go. If SDA stays low, it gives up once a programmed pulse count is reached. It can then finish with a stop condition, so the slave state machines on the bus return to idle.

All timing comes from an external single-cycle half-period tick, so one pulse spans two ticks. Configuration is written to a staging register and takes effect only through a load handshake. Completion sets a sticky interrupt-status bit and records in a status flag whether the bus was actually freed. The enable bit clears itself on completion. The main bus master must stay off the bus while `busy` is high.

Top module: `i2c_busclr`

## Requirements
- R1: A write to the staging configuration (`cfg_we`) changes neither `cfg_active` nor the engine until `cfg_load` is pulsed. `cfg_load_pend` is high for the one cycle between the request and the update of the active configuration.
- R2: When the loaded active configuration has bit 0 (enable) set, the engine raises `busy` and drives SCL low (`scl_oe`=1) at the next half tick. While `busy` is low, neither line is driven.
- R3: Each pulse holds SCL low for exactly one half period (8 clocks with the bench tick) and then releases it for one half period. `scl_oe` changes only on the clock edge that samples a half tick.
- R4: If SDA reads high at the half tick that ends a released phase, clocking stops after that pulse. The number of pulses equals the pulse during which the slave released SDA.
- R5: The pulse limit is the field at bits [16 +: CNT_W] of the configuration. With SDA still low, exactly that many pulses are driven. A limit of 0 gives one pulse.
- R6: With configuration bit 1 set, recovery ends with a stop sequence, each step lasting one half period: SCL low, then SDA driven low while SCL is low, then SCL released, then SDA released while SCL is high.
- R7: With configuration bit 1 clear, `sda_oe` is never asserted.
- R8: Completion sets bit 11 of `int_status`, and all other bits read 0. The bit stays set until `int_ack` is pulsed; a completion in the same cycle as `int_ack` keeps the bit set.
- R9: At completion `clr_released` becomes 1 if SDA was seen high, and 0 if the pulse limit was reached with SDA low.
- R10: On the same clock edge that drops `busy`, bit 0 of `cfg_active` returns to 0.
- R11: After reset both lines are released, `busy` is low, and `cfg_active`, `int_status` and `clr_released` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Single-cycle pulse marking each SCL half period |
| cfg_wdata | input | DATA_W | Staging configuration word: bit 0 enable, bit 1 stop request, bits [16 +: CNT_W] pulse limit |
| cfg_we | input | 1 | Write strobe for the staging configuration |
| cfg_load | input | 1 | Load request: copies staging into the active configuration |
| int_ack | input | 1 | Clears the completion interrupt bit |
| sda_in | input | 1 | Sampled SDA line level |
| cfg_load_pend | output | 1 | Load handshake in progress |
| cfg_active | output | DATA_W | Active configuration readback |
| int_status | output | DATA_W | Interrupt status, bit 11 = recovery complete |
| clr_released | output | 1 | Result of the last recovery: 1 = SDA freed |
| busy | output | 1 | Engine owns the bus |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench builds the block with a 5-bit pulse-limit field (CNT_W = 5) and a two-stage SDA synchronizer. The narrow field makes the largest limit (31) cheap to run in full, alongside the common limit of nine. The two synchronizer stages test that the high-phase sample still sees a slave release that happened at the SCL rising edge. A stuck-slave model releases SDA after a chosen number of pulses. This covers early release, release on exactly the last allowed pulse, never releasing, and a zero limit, each with and without the closing stop sequence.

// File: rtl/bc_pkg.sv
package bc_pkg;
   // Configuration field positions decoded by the register stage
   localparam int BC_EN_BIT    = 0;
   localparam int BC_STOP_BIT  = 1;
   localparam int BC_THR_LSB   = 16;
   // Interrupt status position of the completion flag
   localparam int BC_INT_DONE  = 11;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_CLK_LO   = 3'd1,
      ST_CLK_HI   = 3'd2,
      ST_SP_LO    = 3'd3,
      ST_SP_DLO   = 3'd4,
      ST_SP_SETUP = 3'd5,
      ST_FINISH   = 3'd6
   } bc_state_e;

   typedef struct packed {
      logic done;
      logic released;
   } bc_result_t;
endpackage

// File: rtl/bc_input_sync.sv
module bc_input_sync #(
   parameter int STAGES   = 2,
   parameter bit RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("bc_input_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= RST_VAL;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [STAGES-1:0] r_chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_chain <= {STAGES{RST_VAL}};
         else        r_chain <= {r_chain[STAGES-2:0], d};
      end
      assign q = r_chain[STAGES-1];
   end
endmodule

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs
   import bc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic              load_req,
   input  logic              int_ack,
   input  bc_result_t        result,
   output logic              act_en,
   output logic              act_stop,
   output logic [CNT_W-1:0]  act_thr,
   output logic              load_pend,
   output logic [DATA_W-1:0] readback,
   output logic [DATA_W-1:0] int_status,
   output logic              released
);
   localparam int THR_MSB = BC_THR_LSB + CNT_W - 1;

   if (THR_MSB >= DATA_W) begin : g_bad_width
      $error("bc_cfg_regs: pulse limit field does not fit in DATA_W");
   end
   if (BC_INT_DONE >= DATA_W) begin : g_bad_int
      $error("bc_cfg_regs: interrupt bit outside DATA_W");
   end

   // Staging copy keeps only the bits the engine decodes
   logic             stg_en, stg_stop;
   logic [CNT_W-1:0] stg_thr;
   logic             int_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_en   <= 1'b0;
         stg_stop <= 1'b0;
         stg_thr  <= '0;
      end else if (we) begin
         stg_en   <= wdata[BC_EN_BIT];
         stg_stop <= wdata[BC_STOP_BIT];
         stg_thr  <= wdata[THR_MSB:BC_THR_LSB];
      end
   end

   // Load handshake: request is latched, then applied on the next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_pend <= 1'b0;
      else        load_pend <= load_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en   <= 1'b0;
         act_stop <= 1'b0;
         act_thr  <= '0;
      end else if (load_pend) begin
         act_en   <= stg_en;
         act_stop <= stg_stop;
         act_thr  <= stg_thr;
      end else if (result.done) begin
         act_en   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             int_done <= 1'b0;
      else if (result.done)   int_done <= 1'b1;
      else if (int_ack)       int_done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           released <= 1'b0;
      else if (result.done) released <= result.released;
   end

   always_comb begin
      readback                       = '0;
      readback[BC_EN_BIT]            = act_en;
      readback[BC_STOP_BIT]          = act_stop;
      readback[THR_MSB:BC_THR_LSB]   = act_thr;
      int_status                     = '0;
      int_status[BC_INT_DONE]        = int_done;
   end
endmodule

// File: rtl/bc_sequencer.sv
module bc_sequencer
   import bc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             stop_req,
   input  logic [CNT_W-1:0] thr,
   input  logic             sda_s,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             busy,
   output bc_result_t       result
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   bc_state_e        state, state_nx;
   logic [CNT_W-1:0] cnt, lim_q;
   logic             stop_q, rel_q;
   logic             end_clk, freed;

   // Decisions taken at the end of a released phase
   assign freed   = sda_s;
   assign end_clk = freed || (cnt >= lim_q);

   always_comb begin
      state_nx = state;
      if (tick) begin
         unique case (state)
            ST_IDLE:     if (en) state_nx = ST_CLK_LO;
            ST_CLK_LO:   state_nx = ST_CLK_HI;
            ST_CLK_HI:   if (end_clk) state_nx = stop_q ? ST_SP_LO : ST_FINISH;
                         else         state_nx = ST_CLK_LO;
            ST_SP_LO:    state_nx = ST_SP_DLO;
            ST_SP_DLO:   state_nx = ST_SP_SETUP;
            ST_SP_SETUP: state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
         endcase
      end else if (state == ST_FINISH) begin
         state_nx = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   // Snapshot of the limit and stop request taken when recovery starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         lim_q  <= ONE;
         stop_q <= 1'b0;
         rel_q  <= 1'b0;
      end else if (tick) begin
         if (state == ST_IDLE && en) begin
            cnt    <= '0;
            lim_q  <= (thr == '0) ? ONE : thr;
            stop_q <= stop_req;
            rel_q  <= 1'b0;
         end else if (state == ST_CLK_LO) begin
            cnt    <= cnt + ONE;
         end else if (state == ST_CLK_HI && end_clk) begin
            rel_q  <= freed;
         end
      end
   end

   assign scl_oe          = (state == ST_CLK_LO) || (state == ST_SP_LO) || (state == ST_SP_DLO);
   assign sda_oe          = (state == ST_SP_DLO) || (state == ST_SP_SETUP);
   assign busy            = (state != ST_IDLE);
   assign result.done     = (state == ST_FINISH);
   assign result.released = rel_q;
endmodule

// File: rtl/i2c_busclr.sv
module i2c_busclr
   import bc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_we,
   input  logic              cfg_load,
   input  logic              int_ack,
   input  logic              sda_in,
   output logic              cfg_load_pend,
   output logic [DATA_W-1:0] cfg_active,
   output logic [DATA_W-1:0] int_status,
   output logic              clr_released,
   output logic              busy,
   output logic              scl_oe,
   output logic              sda_oe
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("i2c_busclr: CNT_W must be at least 1");
   end

   logic             sda_s;
   logic             act_en, act_stop;
   logic [CNT_W-1:0] act_thr;
   bc_result_t       result;

   bc_input_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   bc_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (cfg_wdata),
      .we         (cfg_we),
      .load_req   (cfg_load),
      .int_ack    (int_ack),
      .result     (result),
      .act_en     (act_en),
      .act_stop   (act_stop),
      .act_thr    (act_thr),
      .load_pend  (cfg_load_pend),
      .readback   (cfg_active),
      .int_status (int_status),
      .released   (clr_released)
   );

   bc_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (half_tick),
      .en       (act_en),
      .stop_req (act_stop),
      .thr      (act_thr),
      .sda_s    (sda_s),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .busy     (busy),
      .result   (result)
   );
endmodule

// File: rtl/i2c_busclr_checker.sv
module i2c_busclr_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              half_tick,
   input logic              cfg_load_pend,
   input logic [DATA_W-1:0] cfg_active,
   input logic [DATA_W-1:0] int_status,
   input logic              busy,
   input logic              scl_oe,
   input logic              sda_oe
);
   assert_lines_free_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   assert_scl_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_oe) |-> $past(half_tick));

   assert_sda_low_under_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> scl_oe);

   assert_stop_edge_with_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_oe);

   assert_int_on_completion_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> int_status[11]);

   assert_enable_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(cfg_load_pend)) |-> !cfg_active[0]);
endmodule

bind i2c_busclr i2c_busclr_checker #(.DATA_W(DATA_W)) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .half_tick     (half_tick),
   .cfg_load_pend (cfg_load_pend),
   .cfg_active    (cfg_active),
   .int_status    (int_status),
   .busy          (busy),
   .scl_oe        (scl_oe),
   .sda_oe        (sda_oe)
);

// File: tb/i2c_busclr_bench.sv
`timescale 1ns/1ps
module i2c_busclr_bench;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 5;
   localparam int HALF   = 8;

   typedef struct {
      int pulses;
      bit rel;
      bit stop;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              half_tick = 1'b0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic              cfg_we = 1'b0, cfg_load = 1'b0, int_ack = 1'b0;
   logic              sda_in;
   logic              cfg_load_pend, clr_released, busy, scl_oe, sda_oe;
   logic [DATA_W-1:0] cfg_active, int_status;

   int  vectors = 0, errors = 0, runs_done = 0;
   bit  slave_hold = 1'b0;
   int  release_at = 0;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   assign sda_in = !(sda_oe || slave_hold);

   i2c_busclr #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_i2c_busclr (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .cfg_wdata(cfg_wdata),
      .cfg_we(cfg_we), .cfg_load(cfg_load), .int_ack(int_ack), .sda_in(sda_in),
      .cfg_load_pend(cfg_load_pend), .cfg_active(cfg_active), .int_status(int_status),
      .clr_released(clr_released), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // Half-period tick source
   initial begin
      forever begin
         repeat (HALF - 1) @(negedge clk);
         half_tick = 1'b1;
         @(negedge clk);
         half_tick = 1'b0;
      end
   end

   // Monitor: bus model, pulse measurement and scoreboard comparison
   bit prev_busy = 0, prev_scl = 0, prev_sda = 0;
   int cyc = 0, low_start = 0, pulse_cnt = 0, bad_low = 0;
   bit stop_ok = 0, sda_order_bad = 0;
   always @(negedge clk) begin
      cyc++;
      if (busy && !prev_busy) begin
         pulse_cnt = 0; bad_low = 0; stop_ok = 0; sda_order_bad = 0;
      end
      if (scl_oe && !prev_scl) low_start = cyc;
      if (!scl_oe && prev_scl && !sda_oe) begin
         pulse_cnt++;
         if (cyc - low_start != HALF) bad_low++;
         if (pulse_cnt == release_at) slave_hold = 1'b0;
      end
      if (sda_oe && !prev_sda && !scl_oe) sda_order_bad = 1;
      if (!sda_oe && prev_sda && !scl_oe && !sda_order_bad) stop_ok = 1;
      if (!busy && prev_busy) begin
         exp_t e;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected completion", 1, 0);
         end else begin
            e = exp_q.pop_front();
            chk(pulse_cnt == e.pulses, e.rel ? "R4 pulse count early release" :
                "R5 pulse count at limit", pulse_cnt, e.pulses);
            chk(bad_low == 0, "R3 low phase length", bad_low, 0);
            chk(clr_released == e.rel, "R9 released status", clr_released, e.rel);
            chk(stop_ok == e.stop, e.stop ? "R6 stop sequence" : "R7 no SDA drive",
                stop_ok, e.stop);
            chk(int_status == (DATA_W'(1) << 11), "R8 interrupt bit 11", int_status, 32'h800);
            chk(cfg_active[0] == 1'b0, "R10 enable self-clear", cfg_active[0], 0);
         end
         runs_done++;
      end
      prev_busy = busy; prev_scl = scl_oe; prev_sda = sda_oe;
   end

   task automatic write_cfg(input int thr, input bit stop, input bit en, input bit load);
      @(negedge clk);
      cfg_wdata = (DATA_W'(thr) << 16) | (DATA_W'(stop) << 1) | DATA_W'(en);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (load) begin
         cfg_load = 1'b1;
         @(negedge clk);
         cfg_load = 1'b0;
         chk(cfg_load_pend == 1'b1, "R1 load pending", cfg_load_pend, 1);
         @(negedge clk);
         chk(cfg_load_pend == 1'b0, "R1 load done", cfg_load_pend, 0);
         chk(cfg_active == cfg_wdata, "R1 active config", cfg_active, cfg_wdata);
      end
   endtask

   task automatic run_case(input int thr, input bit stop, input int k);
      exp_t e;
      int lim;
      int target;
      lim = (thr == 0) ? 1 : thr;
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      chk(int_status[11] == 1'b0, "R8 interrupt cleared by ack", int_status[11], 0);
      release_at = k;
      slave_hold = 1'b1;
      e.pulses = (k < lim) ? k : lim;
      e.rel    = (k <= lim);
      e.stop   = stop;
      exp_q.push_back(e);
      target = runs_done + 1;
      write_cfg(thr, stop, 1'b1, 1'b1);
      repeat (HALF + 2) @(negedge clk);
      chk(busy == 1'b1, "R2 engine started", busy, 1);
      while (runs_done < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(scl_oe == 0 && sda_oe == 0, "R11 lines released", {scl_oe, sda_oe}, 0);
      chk(busy == 0, "R11 idle", busy, 0);
      chk(cfg_active == 0, "R11 config cleared", cfg_active, 0);
      chk(int_status == 0, "R11 interrupt cleared", int_status, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(clr_released == 0, "R11 status cleared", clr_released, 0);

      // Staged write without load must not start anything
      slave_hold = 1'b1;
      release_at = 1000;
      write_cfg(9, 1'b1, 1'b1, 1'b0);
      repeat (40) @(negedge clk);
      chk(cfg_active == 0, "R1 staged only", cfg_active, 0);
      chk(busy == 0 && scl_oe == 0, "R1 no start without load", busy, 0);

      run_case(9, 1'b1, 3);     // early release, stop
      run_case(9, 1'b0, 1000);  // limit reached, no stop
      run_case(9, 1'b1, 9);     // release on last allowed pulse
      run_case(0, 1'b0, 1000);  // zero limit acts as one pulse
      run_case(31, 1'b0, 1000); // largest limit
      run_case(4, 1'b1, 1);     // released on first pulse
      run_case(2, 1'b1, 1000);  // stop after unsuccessful recovery

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule